// File: doc/BRIEF.md
# Register-mapped GPIO port

This block is a bank of general-purpose I/O lines controlled through a small synchronous register bus: an address, a write strobe with write data, and a read-data output. Software drives line levels through an output latch, chooses per line whether the line is an output or an input, and samples the line levels. The number of lines equals the register width, which is a parameter (8, 16, 32 or 64).

The output latch has two update styles, chosen by a parameter. With a clear register present, one register raises the lines written as 1 and another lowers the lines written as 1. Without it, the set register holds the whole output word. Direction is one shared state with two views. One register shows a 1 for each output line. The other shows a 1 for each input line and always reads as the inverse of the first. A mirror parameter reverses line numbering across every register, so that line n sits at register bit WIDTH-1-n.

The register bus is a plain control interface with no handshake. A write takes effect at the rising edge where the strobe is high, and read data is always presented for the address seen at the previous rising edge.

Top module: `mmio_gpio_port`

## Requirements
- R1: After reset the output latch is all zeros, every line is an input (pin_oe all zeros), the direction-out register (address 3) reads zero and the direction-in register (address 4) reads all ones.
- R2: Address 0 (data) reads the line levels from pin_in through a two-flop synchronizer. A change on pin_in shows in the read data captured at the third rising edge after the change. Writes to address 0 are ignored.
- R3: With the clear register present, writing address 1 (set) sets every latch bit written as 1 and leaves the others unchanged.
- R4: With the clear register present, writing address 2 (clear) clears every latch bit written as 1 and leaves the others unchanged. Address 2 always reads zero.
- R5: Without the clear register, writing address 1 loads the whole latch: written 1s drive high and written 0s drive low. Writes to address 2 are ignored.
- R6: Writing address 3 sets the direction state, where 1 means output. pin_oe follows from the next cycle, and address 3 reads the state back.
- R7: Writing address 4 sets the same direction state inverted, where 1 means input. Address 4 always reads as the bitwise inverse of address 3.
- R8: Address 1 reads the output latch, not the pin levels, whatever the direction of the line.
- R9: With MIRROR set, logical line n (pin bit n) maps to register bit WIDTH-1-n in all registers. With MIRROR clear, it maps to bit n.
- R10: bus_rdata is registered. It holds the value of the register addressed at the previous rising edge.
- R11: Addresses 5 to 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Sampled line levels |
| pin_out | output | WIDTH | Driven line values |
| pin_oe | output | WIDTH | Per-line output enable |

## Verification
Each result has a fixed delay. A register write shows on pin_out and pin_oe one rising edge after the write edge. A read returns data at the rising edge after the address is presented. A pin_in change needs three edges before a data read returns it. The driver records, for every read it issues, the cycle number when the result is due. The monitor compares bus_rdata at the falling edge of exactly that cycle. Pin outputs are checked at the falling edge after the write. The synchronizer test issues back-to-back data reads so that the old value is seen twice before the new one arrives.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_DATA    = 3'd0,
    RA_SET     = 3'd1,
    RA_CLR     = 3'd2,
    RA_DIR_OUT = 3'd3,
    RA_DIR_IN  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_bit_mirror.sv
module gpio_bit_mirror #(
  parameter int unsigned WIDTH = 32,
  parameter bit          EN    = 1'b0
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (EN) begin : g_rev
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = din[WIDTH-1-i];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          HAS_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q
);
  generate
    if (HAS_CLEAR) begin : g_w1
      logic [WIDTH-1:0] set_mask;
      logic [WIDTH-1:0] clr_mask;
      assign set_mask = set_we ? wdata : '0;
      assign clr_mask = clr_we ? wdata : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q | set_mask) & ~clr_mask;
      end
    end else begin : g_load
      logic unused_clr;
      assign unused_clr = clr_we;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      latch_q <= '0;
        else if (set_we) latch_q <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/mmio_gpio_port.sv
module mmio_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter bit          HAS_CLEAR = 1'b1,
  parameter bit          MIRROR    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] sync_pins;
  logic [WIDTH-1:0] level_reg;
  logic [WIDTH-1:0] latch_reg;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] rd_mux;
  logic             set_we;
  logic             clr_we;
  reg_addr_e        addr;

  assign addr   = reg_addr_e'(bus_addr);
  assign set_we = bus_wr && (addr == RA_SET);
  assign clr_we = HAS_CLEAR && bus_wr && (addr == RA_CLR);

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sync_pins)
  );

  gpio_bit_mirror #(.WIDTH(WIDTH), .EN(MIRROR)) u_mir_in (
    .din(sync_pins), .dout(level_reg)
  );

  gpio_out_latch #(.WIDTH(WIDTH), .HAS_CLEAR(HAS_CLEAR)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wdata(bus_wdata), .latch_q(latch_reg)
  );

  // Single direction state, register-bit order, 1 = output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (bus_wr) begin
      if (addr == RA_DIR_OUT)     dir_q <= bus_wdata;
      else if (addr == RA_DIR_IN) dir_q <= ~bus_wdata;
    end
  end

  gpio_bit_mirror #(.WIDTH(WIDTH), .EN(MIRROR)) u_mir_out (
    .din(latch_reg), .dout(pin_out)
  );

  gpio_bit_mirror #(.WIDTH(WIDTH), .EN(MIRROR)) u_mir_oe (
    .din(dir_q), .dout(pin_oe)
  );

  always_comb begin
    unique case (bus_addr)
      RA_DATA:    rd_mux = level_reg;
      RA_SET:     rd_mux = latch_reg;
      RA_DIR_OUT: rd_mux = dir_q;
      RA_DIR_IN:  rd_mux = ~dir_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mmio_gpio_port_chk.sv
module mmio_gpio_port_chk #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          HAS_CLEAR = 1'b1,
  parameter bit          MIRROR    = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       bus_addr,
  input logic             bus_wr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] out_reg;
  logic [WIDTH-1:0] oe_reg;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      out_reg[i] = MIRROR ? pin_out[WIDTH-1-i] : pin_out[i];
      oe_reg[i]  = MIRROR ? pin_oe[WIDTH-1-i]  : pin_oe[i];
    end
  end

  generate
    if (HAS_CLEAR) begin : g_w1
      AST_SET_W1S: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> ((out_reg & $past(bus_wdata)) == $past(bus_wdata))); // R3
      AST_CLR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2) |=> ((out_reg & $past(bus_wdata)) == '0)); // R4
    end else begin : g_load
      AST_SET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> (out_reg == $past(bus_wdata))); // R5
      AST_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2) |=> $stable(pin_out)); // R5
    end
  endgenerate

  AST_DIR_OUT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=> (oe_reg == $past(bus_wdata))); // R6
  AST_DIR_IN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4) |=> (oe_reg == ~$past(bus_wdata))); // R7
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > 3'd4) |=> ($stable(pin_out) && $stable(pin_oe))); // R11
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 3'd4) |=> (bus_rdata == '0)); // R11
  AST_DIR_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd3) |=> (bus_rdata == $past(oe_reg))); // R10
endmodule

bind mmio_gpio_port mmio_gpio_port_chk #(
  .WIDTH(WIDTH), .HAS_CLEAR(HAS_CLEAR), .MIRROR(MIRROR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/mmio_gpio_port_tb_top.sv
`timescale 1ns/1ps
module mmio_gpio_port_tb_top;
  localparam int W  = 32;
  localparam int WM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pin_in = '0;
  logic [W-1:0]  pin_out;
  logic [W-1:0]  pin_oe;

  logic [2:0]    m_addr = '0;
  logic          m_wr = 1'b0;
  logic [WM-1:0] m_wdata = '0;
  logic [WM-1:0] m_rdata;
  logic [WM-1:0] m_pin_in = '0;
  logic [WM-1:0] m_pin_out;
  logic [WM-1:0] m_pin_oe;

  mmio_gpio_port #(.WIDTH(W), .HAS_CLEAR(1'b1), .MIRROR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  mmio_gpio_port #(.WIDTH(WM), .HAS_CLEAR(1'b0), .MIRROR(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .bus_addr(m_addr), .bus_wr(m_wr),
    .bus_wdata(m_wdata), .bus_rdata(m_rdata), .pin_in(m_pin_in),
    .pin_out(m_pin_out), .pin_oe(m_pin_oe)
  );

  typedef struct {
    int          due;
    logic [63:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data in the cycle each item is due.
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, 64'(bus_rdata), it.exp);
    end
  end

  // Driver tasks start and end at a falling edge.
  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string tag);
    bus_addr = a;
    bus_wr   = 1'b0;
    sb_q.push_back('{cyc + 1, 64'(exp), tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_m(input logic [2:0] a, input logic [WM-1:0] exp, input string tag);
    m_addr = a;
    m_wr   = 1'b0;
    @(negedge clk);
    chk(tag, 64'(m_rdata), 64'(exp));
  endtask

  task automatic wr_m(input logic [2:0] a, input logic [WM-1:0] d);
    m_addr  = a;
    m_wdata = d;
    m_wr    = 1'b1;
    @(negedge clk);
    m_wr    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", 64'(pin_out), 64'h0);
    chk("R1 pin_oe", 64'(pin_oe), 64'h0);
    rd(3'd3, 32'h0, "R1 dir-out");
    rd(3'd4, 32'hFFFF_FFFF, "R1 dir-in");
    rd(3'd1, 32'h0, "R1 set readback");

    // R3 write one to set
    wr(3'd1, 32'hA5A5_0000);
    chk("R3 pin_out", 64'(pin_out), 64'hA5A5_0000);
    wr(3'd1, 32'h0000_00FF);
    chk("R3 pin_out accumulate", 64'(pin_out), 64'hA5A5_00FF);
    // R10 read returns the register addressed at the previous edge
    rd(3'd1, 32'hA5A5_00FF, "R10 set readback");

    // R4 write one to clear
    wr(3'd2, 32'h0500_000F);
    chk("R4 pin_out", 64'(pin_out), 64'hA0A5_00F0);
    wr(3'd2, 32'h0);
    chk("R4 zero write", 64'(pin_out), 64'hA0A5_00F0);
    rd(3'd2, 32'h0, "R4 clear reads zero");

    // R6 and R7 shared direction state
    wr(3'd3, 32'hF0F0_F0F0);
    chk("R6 pin_oe", 64'(pin_oe), 64'hF0F0_F0F0);
    rd(3'd3, 32'hF0F0_F0F0, "R6 dir-out read");
    rd(3'd4, 32'h0F0F_0F0F, "R7 dir-in view");
    wr(3'd4, 32'h0000_FFFF);
    chk("R7 pin_oe", 64'(pin_oe), 64'hFFFF_0000);
    rd(3'd3, 32'hFFFF_0000, "R7 dir-out after dir-in write");

    // R2 data writes ignored; R8 set reads latch, not pins
    pin_in = 32'h1357_9BDF;
    wr(3'd0, 32'h1234_5678);
    chk("R2 data write ignored", 64'(pin_out), 64'hA0A5_00F0);
    rd(3'd1, 32'hA0A5_00F0, "R8 set reads latch");

    // R2 synchronizer latency: old, old, then new
    repeat (3) @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    rd(3'd0, 32'h1357_9BDF, "R2 edge1 old");
    rd(3'd0, 32'h1357_9BDF, "R2 edge2 old");
    rd(3'd0, 32'hDEAD_BEEF, "R2 edge3 new");

    // R11 unmapped
    rd(3'd5, 32'h0, "R11 read 5");
    rd(3'd7, 32'h0, "R11 read 7");
    wr(3'd6, 32'hFFFF_FFFF);
    chk("R11 pin_out", 64'(pin_out), 64'hA0A5_00F0);
    chk("R11 pin_oe", 64'(pin_oe), 64'hFFFF_0000);
    rd(3'd1, 32'hA0A5_00F0, "R11 set unchanged");
    repeat (3) @(negedge clk);

    // R9 and R5 on the mirrored instance without a clear register
    wr_m(3'd1, 8'h01);
    chk("R9 mirrored pin_out", 64'(m_pin_out), 64'h80);
    rd_m(3'd1, 8'h01, "R9 set readback");
    wr_m(3'd1, 8'h03);
    wr_m(3'd1, 8'h02);
    chk("R5 load replaces", 64'(m_pin_out), 64'h40);
    wr_m(3'd2, 8'hFF);
    chk("R5 clear ignored", 64'(m_pin_out), 64'h40);
    rd_m(3'd2, 8'h00, "R5 clear reads zero");
    wr_m(3'd3, 8'h0F);
    chk("R9 mirrored pin_oe", 64'(m_pin_oe), 64'hF0);
    m_pin_in = 8'h01;
    repeat (4) @(negedge clk);
    rd_m(3'd0, 8'h80, "R9 mirrored data");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) chk("R10 scoreboard drained", 64'(sb_q.size()), 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule